// File: doc/BRIEF.md
# Miss Buffer Allocation and Blocking Controller

This block sits beside the request buffers of a non-blocking cache. It keeps track of which slots are taken in two queues, one for outstanding misses and one for writes and writebacks. It hands out a slot index and an order tag for each allocation. It also raises memory-side bus requests and keeps the mask of reasons that stall the CPU-side request port. Every successful allocation receives a tag from a single counter shared by both queues, so downstream logic can recover the global issue order.

The stall is driven by a three-bit mask of independent causes: the miss queue is full, the write queue is full, or an external no-free-targets condition holds. The port stalls as soon as any cause is present. It is released only once every cause has gone. For each cause the block counts how many stall episodes it opened, and how many cycles the stall lasted for episodes that ended with that cause. An optional limit counts miss-queue allocations and gives a one-cycle pulse when the count is used up.

Top module: `miss_alloc_ctrl`

## Requirements
- R1: After synchronous reset both queues are empty, the order counter is zero, the cause mask is 0, cpu_stall is low, every episode and cycle counter reads zero, and resp_valid, resp_err and bus_req_valid are low.
- R2: An accepted allocation takes the lowest free slot of the selected queue (alloc_to_wb=0 selects the miss queue, 1 the write queue). One cycle later resp_valid pulses with that slot in resp_idx. resp_order carries a tag that starts at 0 and rises by one per accepted allocation across both queues.
- R3: An allocation into a full queue sets resp_err for one cycle and gives no resp_valid and no bus request. It leaves the order counter unchanged and overwrites no slot.
- R4: A cacheable miss allocation (miss queue, alloc_uncached=0) reports the address with its low log2(BLK_BYTES) bits cleared, and size BLK_BYTES. Write-queue and uncached allocations report the exact address and size.
- R5: An allocation that fills a queue sets its cause bit in block_mask (bit 0 for the miss queue, bit 1 for the write queue). cpu_stall is high in the following cycle.
- R6: A service pulse clears a queue's cause bit only when that queue was full and is no longer full afterwards. A service on a slot that is not taken changes nothing.
- R7: tgt_block_set sets mask bit 2 and tgt_block_clr clears it. If both are high in the same cycle, the bit ends up set.
- R8: cpu_stall stays high while any mask bit is set. It falls only in the cycle after the mask becomes all zero.
- R9: When the mask goes from zero to non-zero, the episode counter of the lowest-numbered new cause increments. Setting further causes while the mask is already non-zero counts nothing.
- R10: When the mask returns to zero, the number of cycles cpu_stall was high is added to the cycle counter of the lowest-numbered cause that was set just before.
- R11: An accepted allocation with alloc_bus_req set raises bus_req_valid one cycle later with bus_req_cause equal to the queue (0 miss, 1 write). Otherwise pf_req raises it with cause 2, and a flagged allocation takes precedence over pf_req.
- R12: With MISS_LIMIT non-zero, miss_limit_done pulses for one cycle right after the MISS_LIMIT-th accepted miss-queue allocation and never again. With MISS_LIMIT zero it never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_to_wb | input | 1 | 0 miss queue, 1 write queue |
| alloc_uncached | input | 1 | Uncached read into the miss queue (no alignment) |
| alloc_addr | input | ADDR_W | Request address |
| alloc_size | input | SIZE_W | Request size in bytes |
| alloc_bus_req | input | 1 | Ask for the memory bus with this allocation |
| svc_valid | input | 1 | Slot marked in service |
| svc_to_wb | input | 1 | Queue of the serviced slot |
| svc_idx | input | IDX_W | Serviced slot |
| tgt_block_set | input | 1 | Raise no-targets cause |
| tgt_block_clr | input | 1 | Drop no-targets cause |
| pf_req | input | 1 | Prefetch bus request |
| resp_valid | output | 1 | Allocation accepted (previous cycle) |
| resp_err | output | 1 | Allocation refused, queue full |
| resp_to_wb | output | 1 | Queue of the accepted allocation |
| resp_idx | output | IDX_W | Slot granted |
| resp_order | output | ORDER_W | Order tag |
| resp_addr | output | ADDR_W | Stored address |
| resp_size | output | SIZE_W | Stored size |
| bus_req_valid | output | 1 | Memory-side bus request |
| bus_req_cause | output | 2 | 0 miss, 1 write, 2 prefetch |
| cpu_stall | output | 1 | CPU-side port stall |
| block_mask | output | 3 | Cause mask |
| blk_events | output | 3*EV_W | Stall episode count per cause |
| blk_cycles | output | 3*CYC_W | Stalled cycles per cause |
| miss_limit_done | output | 1 | Miss limit reached pulse |

## Verification
The bench first fills the miss queue slot by slot, alternating the bus flag, and with addresses that have non-zero low bits. This separates alignment from pass-through and also hits the miss-limit pulse. Next come a refused allocation into the full queue and the two write-queue allocations: the refused one must not advance the order, and the write-queue fill must not open a second stall episode. The bench then services slots in an order that clears one cause while another still holds and re-fills a slot in the gap. This shows whether the stall waits for an empty mask and which cause receives the cycle count. Last, the no-targets cause is set and cleared together, and prefetch is raised with and without flagged allocations, which exercises set priority and bus cause priority.

// File: rtl/mab_pkg.sv
package mab_pkg;

    localparam int NUM_CAUSES = 3;

    typedef enum logic [1:0] {
        REQ_MISS = 2'd0,
        REQ_WB   = 2'd1,
        REQ_PF   = 2'd2
    } req_cause_e;

    typedef enum logic [1:0] {
        BLK_MISS_FULL = 2'd0,
        BLK_WB_FULL   = 2'd1,
        BLK_NO_TGT    = 2'd2
    } blk_cause_e;

    typedef struct packed {
        logic       valid;
        req_cause_e cause;
    } bus_req_t;

    function automatic blk_cause_e first_cause(input logic [NUM_CAUSES-1:0] v);
        if (v[0])      return BLK_MISS_FULL;
        else if (v[1]) return BLK_WB_FULL;
        else           return BLK_NO_TGT;
    endfunction

endpackage

// File: rtl/mab_buf_track.sv
module mab_buf_track #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic             svc_req,
    input  logic [IDX_W-1:0] svc_idx,
    output logic             grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             full,
    output logic             fill_evt,
    output logic             drain_evt
);
    logic [DEPTH-1:0] busy_q, busy_d, take, drop;

    // lowest free slot
    always_comb begin
        grant_idx = '0;
        for (int k = DEPTH-1; k >= 0; k--) begin
            if (!busy_q[k]) grant_idx = IDX_W'(k);
        end
    end

    assign full  = &busy_q;
    assign grant = alloc_req && !full;

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            take[k] = grant && (grant_idx == IDX_W'(k));
            drop[k] = svc_req && (svc_idx == IDX_W'(k));
        end
        busy_d = (busy_q & ~drop) | take;
    end

    assign fill_evt  = grant && (&busy_d);
    assign drain_evt = full && !(&busy_d);

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= busy_d;
    end

    // R3: a full queue stays full unless a slot is serviced
    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (full && !svc_req) |=> full);

endmodule

// File: rtl/mab_block_ctrl.sv
module mab_block_ctrl
    import mab_pkg::*;
#(
    parameter int EV_W  = 16,
    parameter int CYC_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CAUSES-1:0]      set_c,
    input  logic [NUM_CAUSES-1:0]      clr_c,
    output logic                       stall,
    output logic [NUM_CAUSES-1:0]      mask,
    output logic [NUM_CAUSES*EV_W-1:0] events,
    output logic [NUM_CAUSES*CYC_W-1:0] cycles
);
    logic [NUM_CAUSES-1:0] mask_q, mask_d;
    logic                  stall_q;
    logic [CYC_W-1:0]      now_q, start_q;
    logic                  rising, falling;
    blk_cause_e            rise_c, fall_c;

    assign mask_d  = (mask_q & ~clr_c) | set_c;   // set wins
    assign rising  = (mask_q == '0) && (mask_d != '0);
    assign falling = (mask_q != '0) && (mask_d == '0);
    assign rise_c  = first_cause(mask_d);
    assign fall_c  = first_cause(mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            stall_q <= 1'b0;
            now_q   <= '0;
            start_q <= '0;
        end else begin
            mask_q  <= mask_d;
            stall_q <= |mask_d;
            now_q   <= now_q + 1'b1;
            if (rising) start_q <= now_q;
        end
    end

    for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause
        logic [EV_W-1:0]  ev_q;
        logic [CYC_W-1:0] cy_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ev_q <= '0;
                cy_q <= '0;
            end else begin
                if (rising && rise_c == blk_cause_e'(c))  ev_q <= ev_q + 1'b1;
                if (falling && fall_c == blk_cause_e'(c)) cy_q <= cy_q + (now_q - start_q);
            end
        end
        assign events[c*EV_W +: EV_W]   = ev_q;
        assign cycles[c*CYC_W +: CYC_W] = cy_q;
    end

    assign stall = stall_q;
    assign mask  = mask_q;

    // R7: any cause set forces the stall next cycle
    p_set_stalls_r7: assert property (@(posedge clk) disable iff (rst)
        (|set_c) |=> stall);
    // R8: stall holds while a cause survives
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (stall && (|(mask_q & ~clr_c))) |=> stall);
    // R8: empty mask with nothing new releases the port
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0 && set_c == '0) |=> !stall);

endmodule

// File: rtl/mab_miss_limit.sv
module mab_miss_limit #(
    parameter int LIMIT = 3,
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic miss,
    output logic done
);
    logic [CNT_W-1:0] remain_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= CNT_W'(LIMIT);
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (miss && remain_q != '0) begin
                remain_q <= remain_q - 1'b1;
                if (remain_q == CNT_W'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;

    // R12: single pulse
    p_done_once_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_spent_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> remain_q == '0);

endmodule

// File: rtl/miss_alloc_ctrl.sv
module miss_alloc_ctrl
    import mab_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 8,
    parameter int BLK_BYTES  = 16,
    parameter int MISS_DEPTH = 4,
    parameter int WB_DEPTH   = 2,
    parameter int ORDER_W    = 16,
    parameter int EV_W       = 16,
    parameter int CYC_W      = 32,
    parameter int MISS_LIMIT = 3,
    localparam int MAX_DEPTH = (MISS_DEPTH > WB_DEPTH) ? MISS_DEPTH : WB_DEPTH,
    localparam int IDX_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_valid,
    input  logic                        alloc_to_wb,
    input  logic                        alloc_uncached,
    input  logic [ADDR_W-1:0]           alloc_addr,
    input  logic [SIZE_W-1:0]           alloc_size,
    input  logic                        alloc_bus_req,
    input  logic                        svc_valid,
    input  logic                        svc_to_wb,
    input  logic [IDX_W-1:0]            svc_idx,
    input  logic                        tgt_block_set,
    input  logic                        tgt_block_clr,
    input  logic                        pf_req,
    output logic                        resp_valid,
    output logic                        resp_err,
    output logic                        resp_to_wb,
    output logic [IDX_W-1:0]            resp_idx,
    output logic [ORDER_W-1:0]          resp_order,
    output logic [ADDR_W-1:0]           resp_addr,
    output logic [SIZE_W-1:0]           resp_size,
    output logic                        bus_req_valid,
    output logic [1:0]                  bus_req_cause,
    output logic                        cpu_stall,
    output logic [2:0]                  block_mask,
    output logic [3*EV_W-1:0]           blk_events,
    output logic [3*CYC_W-1:0]          blk_cycles,
    output logic                        miss_limit_done
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);

    logic [1:0]       q_req, q_svc, q_grant, q_full, q_fill, q_drain;
    logic [IDX_W-1:0] q_idx [2];

    for (genvar q = 0; q < 2; q++) begin : g_queue
        localparam int D = (q == 0) ? MISS_DEPTH : WB_DEPTH;
        assign q_req[q] = alloc_valid && (alloc_to_wb == 1'(q));
        assign q_svc[q] = svc_valid && (svc_to_wb == 1'(q));
        mab_buf_track #(.DEPTH(D), .IDX_W(IDX_W)) u_trk (
            .clk       (clk),
            .rst       (rst),
            .alloc_req (q_req[q]),
            .svc_req   (q_svc[q]),
            .svc_idx   (svc_idx),
            .grant     (q_grant[q]),
            .grant_idx (q_idx[q]),
            .full      (q_full[q]),
            .fill_evt  (q_fill[q]),
            .drain_evt (q_drain[q])
        );
    end

    logic             grant, cached;
    logic [ADDR_W-1:0] addr_d;
    logic [SIZE_W-1:0] size_d;
    bus_req_t          bus_d, bus_q;
    logic [ORDER_W-1:0] order_q;

    assign grant  = |q_grant;
    assign cached = !alloc_to_wb && !alloc_uncached;
    assign addr_d = cached ? (alloc_addr & ~OFF_MASK) : alloc_addr;
    assign size_d = cached ? SIZE_W'(BLK_BYTES) : alloc_size;

    always_comb begin
        bus_d = '{valid: 1'b0, cause: REQ_MISS};
        if (grant && alloc_bus_req)
            bus_d = '{valid: 1'b1, cause: alloc_to_wb ? REQ_WB : REQ_MISS};
        else if (pf_req)
            bus_d = '{valid: 1'b1, cause: REQ_PF};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_to_wb <= 1'b0;
            resp_idx   <= '0;
            resp_order <= '0;
            resp_addr  <= '0;
            resp_size  <= '0;
            order_q    <= '0;
            bus_q      <= '0;
        end else begin
            resp_valid <= grant;
            resp_err   <= alloc_valid && !grant;
            bus_q      <= bus_d;
            if (grant) begin
                resp_to_wb <= alloc_to_wb;
                resp_idx   <= alloc_to_wb ? q_idx[1] : q_idx[0];
                resp_order <= order_q;
                resp_addr  <= addr_d;
                resp_size  <= size_d;
                order_q    <= order_q + 1'b1;
            end
        end
    end

    assign bus_req_valid = bus_q.valid;
    assign bus_req_cause = bus_q.cause;

    mab_block_ctrl #(.EV_W(EV_W), .CYC_W(CYC_W)) u_blk (
        .clk    (clk),
        .rst    (rst),
        .set_c  ({tgt_block_set, q_fill}),
        .clr_c  ({tgt_block_clr, q_drain}),
        .stall  (cpu_stall),
        .mask   (block_mask),
        .events (blk_events),
        .cycles (blk_cycles)
    );

    mab_miss_limit #(.LIMIT(MISS_LIMIT), .CNT_W(32)) u_lim (
        .clk  (clk),
        .rst  (rst),
        .miss (q_grant[0]),
        .done (miss_limit_done)
    );

    // R2: order advances by exactly one per accepted allocation
    p_order_step_r2: assert property (@(posedge clk) disable iff (rst)
        grant |=> order_q == $past(order_q) + 1'b1);
    // R11: a queue-caused bus request belongs to the allocation just granted
    p_bus_cause_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_cause != REQ_PF) |->
            (resp_valid && bus_req_cause == {1'b0, resp_to_wb}));
    // R5: filling a queue stalls the port next cycle
    p_fill_stalls_r5: assert property (@(posedge clk) disable iff (rst)
        (q_fill != 2'b00) |=> cpu_stall);

endmodule

// File: tb/miss_alloc_ctrl_test.sv
module miss_alloc_ctrl_test;
    localparam int CLK_P = 10;
    localparam int EV_W  = 16;
    localparam int CYC_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid, alloc_to_wb, alloc_uncached, alloc_bus_req;
    logic [15:0] alloc_addr;
    logic [7:0]  alloc_size;
    logic svc_valid, svc_to_wb;
    logic [1:0] svc_idx;
    logic tgt_block_set, tgt_block_clr, pf_req;

    logic resp_valid, resp_err, resp_to_wb;
    logic [1:0] resp_idx;
    logic [15:0] resp_order, resp_addr;
    logic [7:0] resp_size;
    logic bus_req_valid;
    logic [1:0] bus_req_cause;
    logic cpu_stall;
    logic [2:0] block_mask;
    logic [3*EV_W-1:0] blk_events;
    logic [3*CYC_W-1:0] blk_cycles;
    logic miss_limit_done;

    logic n_rv, n_re, n_rw, n_bv, n_st, n_done;
    logic [1:0] n_ri, n_bc;
    logic [15:0] n_ro, n_ra;
    logic [7:0] n_rs;
    logic [2:0] n_bm;
    logic [3*EV_W-1:0] n_ev;
    logic [3*CYC_W-1:0] n_cy;

    int checks = 0;
    int failures = 0;
    int n = 0;
    bit nolim_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    miss_alloc_ctrl uut (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_to_wb(alloc_to_wb),
        .alloc_uncached(alloc_uncached), .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .alloc_bus_req(alloc_bus_req), .svc_valid(svc_valid), .svc_to_wb(svc_to_wb),
        .svc_idx(svc_idx), .tgt_block_set(tgt_block_set), .tgt_block_clr(tgt_block_clr),
        .pf_req(pf_req), .resp_valid(resp_valid), .resp_err(resp_err), .resp_to_wb(resp_to_wb),
        .resp_idx(resp_idx), .resp_order(resp_order), .resp_addr(resp_addr),
        .resp_size(resp_size), .bus_req_valid(bus_req_valid), .bus_req_cause(bus_req_cause),
        .cpu_stall(cpu_stall), .block_mask(block_mask), .blk_events(blk_events),
        .blk_cycles(blk_cycles), .miss_limit_done(miss_limit_done)
    );

    miss_alloc_ctrl #(.MISS_LIMIT(0)) uut_nolim (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_to_wb(alloc_to_wb),
        .alloc_uncached(alloc_uncached), .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .alloc_bus_req(alloc_bus_req), .svc_valid(svc_valid), .svc_to_wb(svc_to_wb),
        .svc_idx(svc_idx), .tgt_block_set(tgt_block_set), .tgt_block_clr(tgt_block_clr),
        .pf_req(pf_req), .resp_valid(n_rv), .resp_err(n_re), .resp_to_wb(n_rw),
        .resp_idx(n_ri), .resp_order(n_ro), .resp_addr(n_ra), .resp_size(n_rs),
        .bus_req_valid(n_bv), .bus_req_cause(n_bc), .cpu_stall(n_st), .block_mask(n_bm),
        .blk_events(n_ev), .blk_cycles(n_cy), .miss_limit_done(n_done)
    );

    always @(negedge clk) if (!rst && n_done) nolim_seen = 1;

    function automatic logic [EV_W-1:0] ev(input int c);
        return blk_events[c*EV_W +: EV_W];
    endfunction
    function automatic logic [CYC_W-1:0] cy(input int c);
        return blk_cycles[c*CYC_W +: CYC_W];
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
        n++;
    endtask

    task automatic idle;
        alloc_valid = 0; alloc_to_wb = 0; alloc_uncached = 0; alloc_bus_req = 0;
        alloc_addr = '0; alloc_size = '0; svc_valid = 0; svc_to_wb = 0; svc_idx = '0;
        tgt_block_set = 0; tgt_block_clr = 0; pf_req = 0;
    endtask

    task automatic alloc(input bit wb, input bit unc, input logic [15:0] a,
                         input logic [7:0] s, input bit br);
        alloc_valid = 1; alloc_to_wb = wb; alloc_uncached = unc;
        alloc_addr = a; alloc_size = s; alloc_bus_req = br;
    endtask

    task automatic svc(input bit wb, input logic [1:0] idx);
        svc_valid = 1; svc_to_wb = wb; svc_idx = idx;
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n_rise, n_fall, n2;
        logic [15:0] a;
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1", "stall", cpu_stall, 0);
        chk("R1", "mask", block_mask, 0);
        chk("R1", "resp_valid", resp_valid, 0);
        chk("R1", "resp_err", resp_err, 0);
        chk("R1", "bus", bus_req_valid, 0);
        chk("R1", "events", blk_events, 0);
        chk("R1", "cycles", blk_cycles, 0);
        n_rise = 0;

        // R2 R4 R5 R11 R12: fill the miss queue
        for (int i = 0; i < 4; i++) begin
            a = 16'h1234 + 16'(i) * 16'h0111;
            alloc(0, 0, a, 8'd5, i[0]);
            tick();
            idle();
            chk("R2", "resp_valid", resp_valid, 1);
            chk("R2", "idx", resp_idx, i);
            chk("R2", "order", resp_order, i);
            chk("R4", "aligned addr", resp_addr, a & 16'hFFF0);
            chk("R4", "block size", resp_size, 16);
            chk("R11", "bus valid", bus_req_valid, i % 2);
            if (i % 2 == 1) chk("R11", "bus cause", bus_req_cause, 0);
            chk("R12", "limit pulse", miss_limit_done, (i == 2) ? 1 : 0);
            chk("R5", "mask", block_mask, (i == 3) ? 1 : 0);
            chk("R5", "stall", cpu_stall, (i == 3) ? 1 : 0);
        end
        n_rise = n;
        chk("R9", "events0", ev(0), 1);

        // R3 full-queue allocation
        alloc(0, 0, 16'h7777, 8'd1, 1);
        tick(); idle();
        chk("R3", "err", resp_err, 1);
        chk("R3", "no resp", resp_valid, 0);
        chk("R3", "no bus", bus_req_valid, 0);
        chk("R12", "no second pulse", miss_limit_done, 0);

        // R2 R4 R9: write queue
        for (int j = 0; j < 2; j++) begin
            a = 16'h4003 + 16'(j) * 16'd5;
            alloc(1, 0, a, 8'(3 + j), 1);
            tick(); idle();
            chk("R2", "wb idx", resp_idx, j);
            chk("R2", "wb order continues", resp_order, 4 + j);
            chk("R4", "wb exact addr", resp_addr, a);
            chk("R4", "wb exact size", resp_size, 3 + j);
            chk("R11", "wb bus cause", bus_req_cause, 1);
        end
        chk("R5", "mask both", block_mask, 3);
        chk("R9", "events1 no new episode", ev(1), 0);

        // R6 R8: drain miss queue by one
        svc(0, 2'd2);
        tick(); idle();
        chk("R6", "mask after drain", block_mask, 2);
        chk("R8", "stall held", cpu_stall, 1);
        chk("R10", "no cycles yet", cy(0), 0);

        // R6 service of a free slot ignored
        svc(0, 2'd2);
        tick(); idle();
        chk("R6", "free svc ignored", block_mask, 2);

        // R2 R3 R4: uncached read into the freed slot
        alloc(0, 1, 16'h2345, 8'd7, 0);
        tick(); idle();
        chk("R3", "no overwrite idx", resp_idx, 2);
        chk("R3", "order skips refused", resp_order, 6);
        chk("R4", "uncached addr", resp_addr, 16'h2345);
        chk("R4", "uncached size", resp_size, 7);
        chk("R11", "no flag no bus", bus_req_valid, 0);
        chk("R5", "refill mask", block_mask, 3);
        chk("R9", "events0 same episode", ev(0), 1);

        // R8 R10: release
        svc(1, 2'd0);
        tick(); idle();
        chk("R6", "wb drain", block_mask, 1);
        svc(0, 2'd1);
        tick(); idle();
        n_fall = n;
        chk("R8", "mask empty", block_mask, 0);
        chk("R8", "stall released", cpu_stall, 0);
        chk("R10", "cycles0", cy(0), n_fall - n_rise);
        chk("R10", "cycles1 untouched", cy(1), 0);

        // R7 no-target cause
        tgt_block_set = 1;
        tick(); idle();
        n2 = n;
        chk("R7", "mask bit2", block_mask, 4);
        chk("R7", "stall", cpu_stall, 1);
        chk("R9", "events2", ev(2), 1);
        tgt_block_set = 1; tgt_block_clr = 1;
        tick(); idle();
        chk("R7", "set wins", block_mask, 4);
        tgt_block_clr = 1;
        tick(); idle();
        chk("R7", "cleared", block_mask, 0);
        chk("R10", "cycles2", cy(2), n - n2);

        // R11 prefetch
        pf_req = 1;
        tick(); idle();
        chk("R11", "pf valid", bus_req_valid, 1);
        chk("R11", "pf cause", bus_req_cause, 2);
        pf_req = 1;
        alloc(1, 0, 16'h5555, 8'd2, 1);
        tick(); idle();
        chk("R11", "alloc beats pf", bus_req_cause, 1);
        chk("R2", "wb lowest free", resp_idx, 0);
        chk("R2", "order", resp_order, 7);
        chk("R9", "events1", ev(1), 1);
        pf_req = 1;
        alloc(0, 0, 16'h6789, 8'd2, 0);
        tick(); idle();
        chk("R11", "unflagged alloc pf cause", bus_req_cause, 2);
        chk("R4", "aligned", resp_addr, 16'h6780);
        chk("R2", "miss idx", resp_idx, 1);
        chk("R5", "both full", block_mask, 3);
        chk("R12", "zero limit never pulses", nolim_seen, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule